// File: doc/BRIEF.md
# MSI Redirect Translator with Entry Cache

This block sits between the message-signalled interrupt fabric and the per-CPU interrupt logic. Each incoming MSI write either names a slot of a redirect table kept in system memory or is not a redirected request at all. For a redirected request the block finds the slot's entry, either in a small fully associative entry cache or by reading the table through a simple memory request/response port. It follows the entry's pointer to a 64-byte target descriptor, checks that the descriptor is enabled, marks the interrupt pending in the descriptor's bitmap and then hands the target CPU id and vector to the CPU side over a valid/ready delivery port.

Software places the table anywhere in memory by writing the table-base register. A command-queue engine drives the invalidate port whenever software rewrites an entry. Cached entries are never refreshed on their own: a cached copy stays in use until an invalidate for its index removes it. One MSI is handled at a time.

Top module: `msir_translator`

## Requirements
- R1: An MSI whose address bit 2 is 1 is a redirected request; address bits 19:4 carry its 16-bit table index, and the MSI data word has no effect on the outcome.
- R2: An MSI whose address bit 2 is 0 is accepted and dropped: no memory request, no delivery and no change to the error flag.
- R3: On a cache miss the block reads the entry doubleword at table-base + index*16; the table base is set through the base-register write port and is 0 after reset. In the entry, bit 0 is the valid flag and bits 47:6 are the descriptor address with its low 6 bits zero.
- R4: The control doubleword of a descriptor sits at descriptor + 32: bit 0 is the enable flag, bits 15:8 the vector and bits 63:32 the destination CPU id. A delivery carries exactly that CPU id and vector.
- R5: Before delivering vector v, the block reads the pending doubleword at descriptor + 8*(v/64) and writes it back with bit v%64 set and every other bit unchanged.
- R6: A delivery holds valid, CPU id and vector stable until accepted; no new MSI is accepted until that delivery completes.
- R7: When the cache holds a valid copy of the requested index, no table read is made, and the cached copy is used even if memory has since changed.
- R8: An invalidate for an index removes any cached copy, so the next MSI to that index reads the table again.
- R9: The cache holds CACHE_DEPTH entries (8 by default) tagged by index and replaced round-robin: the fill after CACHE_DEPTH fills overwrites the oldest entry.
- R10: An invalidate for the index being fetched, arriving while the table read is in flight, keeps that fetch's result out of the cache; the MSI itself is still delivered.
- R11: An entry with valid flag 0, or a descriptor with enable flag 0, produces no pending update and no delivery, and sets an error flag that stays set until reset.
- R12: After reset the block is ready for an MSI, issues no memory request, has no delivery pending, its error flag is clear and its cache is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| msi_valid | input | 1 | MSI write present |
| msi_ready | output | 1 | Block can take an MSI |
| msi_addr | input | ADDR_W | MSI write address |
| msi_data | input | MSI_DW | MSI write data (no effect) |
| tbl_base_we | input | 1 | Load the table-base register |
| tbl_base_wdata | input | PA_W | New table base |
| inv_valid | input | 1 | Invalidate request |
| inv_index | input | 16 | Index to invalidate |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_write | output | 1 | 1 for a write, 0 for a read |
| mem_req_addr | output | PA_W | Byte address of the doubleword |
| mem_req_wdata | output | DW | Write data |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | DW | Read data |
| dlv_valid | output | 1 | Delivery request present |
| dlv_ready | input | 1 | CPU side takes the delivery |
| dlv_cpu | output | 32 | Destination CPU id |
| dlv_vec | output | 8 | Vector number |
| err_flag | output | 1 | Sticky error flag |

## Verification
On every cycle the assertions check the handshake rules of the delivery and memory ports, that the error flag never drops outside reset, that a dropped non-redirected MSI leaves the block idle, and that a cache hit goes straight to the descriptor read. What the cache holds, which entry round-robin replacement evicts, whether an invalidate racing a fetch kept the result out of the cache, and whether the pending bit lands in the right doubleword only show up through the bench's scenarios, which count table reads and inspect the memory model after each MSI.

// File: rtl/msir_pkg.sv
package msir_pkg;

   // Fixed layout of the redirect structures
   localparam int IDX_W         = 16;  // table index width
   localparam int IDX_LSB       = 4;   // index position in the MSI address
   localparam int REDIR_BIT     = 2;   // address bit marking a redirected MSI
   localparam int ENTRY_SHIFT   = 4;   // 16-byte table entries
   localparam int DESC_SHIFT    = 6;   // 64-byte descriptors
   localparam int CTRL_OFS      = 32;  // byte offset of the control doubleword
   localparam int ENT_VALID_BIT = 0;
   localparam int CTRL_EN_BIT   = 0;
   localparam int CTRL_VEC_LSB  = 8;
   localparam int CTRL_CPU_LSB  = 32;
   localparam int VEC_W         = 8;
   localparam int CPU_W         = 32;

   typedef enum logic [3:0] {
      WS_IDLE,
      WS_ENT_REQ,
      WS_ENT_WAIT,
      WS_CTRL_REQ,
      WS_CTRL_WAIT,
      WS_PEND_REQ,
      WS_PEND_WAIT,
      WS_PEND_WR,
      WS_DLV
   } walk_state_e;

endpackage

// File: rtl/msir_decode.sv
module msir_decode
   import msir_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              redir,
   output logic [IDX_W-1:0]  index
);

   if (ADDR_W < IDX_LSB + IDX_W) begin : g_bad_addr_w
      $error("msir_decode: ADDR_W too small to carry the index");
   end

   assign redir = addr[REDIR_BIT];
   assign index = addr[IDX_LSB +: IDX_W];

   logic unused_addr_bits;
   assign unused_addr_bits = ^addr;

endmodule

// File: rtl/msir_entry_cache.sv
module msir_entry_cache #(
   parameter int DEPTH  = 8,
   parameter int TAG_W  = 16,
   parameter int DATA_W = 42
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TAG_W-1:0]  lk_tag,
   output logic              lk_hit,
   output logic [DATA_W-1:0] lk_data,
   input  logic              fill_en,
   input  logic [TAG_W-1:0]  fill_tag,
   input  logic [DATA_W-1:0] fill_data,
   input  logic              inv_en,
   input  logic [TAG_W-1:0]  inv_tag
);

   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("msir_entry_cache: DEPTH must be a power of two, at least 2");
   end

   logic [DEPTH-1:0]  match;
   logic [DATA_W-1:0] way_data [DEPTH];
   logic [PW-1:0]     rr_q;

   for (genvar g = 0; g < DEPTH; g++) begin : g_way
      logic              v_q;
      logic [TAG_W-1:0]  t_q;
      logic [DATA_W-1:0] d_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            t_q <= '0;
            d_q <= '0;
         end else if (fill_en && rr_q == PW'(g)) begin
            v_q <= 1'b1;
            t_q <= fill_tag;
            d_q <= fill_data;
         end else if (inv_en && v_q && t_q == inv_tag) begin
            v_q <= 1'b0;
         end
      end

      assign match[g]    = v_q && (t_q == lk_tag);
      assign way_data[g] = d_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rr_q <= '0;
      else if (fill_en) rr_q <= rr_q + 1'b1;
   end

   always_comb begin
      lk_data = '0;
      for (int w = 0; w < DEPTH; w++) begin
         if (match[w]) lk_data = lk_data | way_data[w];
      end
   end

   assign lk_hit = |match;

endmodule

// File: rtl/msir_walker.sv
module msir_walker
   import msir_pkg::*;
#(
   parameter int PA_W = 48,
   parameter int DW   = 64
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_valid,
   output logic                       req_ready,
   input  logic                       req_redir,
   input  logic [IDX_W-1:0]           req_index,
   input  logic [PA_W-1:0]            tbl_base,
   input  logic                       lk_hit,
   input  logic [PA_W-DESC_SHIFT-1:0] lk_ptr,
   output logic                       fill_en,
   output logic [IDX_W-1:0]           fill_tag,
   output logic [PA_W-DESC_SHIFT-1:0] fill_ptr,
   input  logic                       inv_valid,
   input  logic [IDX_W-1:0]           inv_index,
   output logic                       mem_req_valid,
   input  logic                       mem_req_ready,
   output logic                       mem_req_write,
   output logic [PA_W-1:0]            mem_req_addr,
   output logic [DW-1:0]              mem_req_wdata,
   input  logic                       mem_rsp_valid,
   input  logic [DW-1:0]              mem_rsp_data,
   output logic                       dlv_valid,
   input  logic                       dlv_ready,
   output logic [CPU_W-1:0]           dlv_cpu,
   output logic [VEC_W-1:0]           dlv_vec,
   output logic                       err_flag
);

   localparam int PTR_W   = PA_W - DESC_SHIFT;
   localparam int WB      = $clog2(DW);      // bit-select width in a word
   localparam int BYTE_SH = $clog2(DW / 8);  // bytes per word, as a shift

   if (DW != 64) begin : g_bad_dw
      $error("msir_walker: the structures are laid out in 64-bit words");
   end
   if (PA_W <= CTRL_VEC_LSB) begin : g_bad_pa_w
      $error("msir_walker: PA_W too small");
   end

   walk_state_e      st_q;
   logic [IDX_W-1:0] idx_q;
   logic [PTR_W-1:0] ptr_q;
   logic [VEC_W-1:0] vec_q;
   logic [CPU_W-1:0] cpu_q;
   logic [DW-1:0]    word_q;
   logic             stale_q;
   logic             err_q;

   logic             inv_same;
   logic             ent_ok;
   logic [PTR_W-1:0] rsp_ptr;
   logic [PA_W-1:0]  desc_addr;

   assign inv_same  = inv_valid && (inv_index == idx_q);
   assign ent_ok    = mem_rsp_data[ENT_VALID_BIT];
   assign rsp_ptr   = mem_rsp_data[PA_W-1:DESC_SHIFT];
   assign desc_addr = {ptr_q, {DESC_SHIFT{1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= WS_IDLE;
         idx_q   <= '0;
         ptr_q   <= '0;
         vec_q   <= '0;
         cpu_q   <= '0;
         word_q  <= '0;
         stale_q <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         case (st_q)
            WS_IDLE: begin
               if (req_valid) begin
                  stale_q <= 1'b0;
                  idx_q   <= req_index;
                  if (req_redir) begin
                     if (lk_hit) begin
                        ptr_q <= lk_ptr;
                        st_q  <= WS_CTRL_REQ;
                     end else begin
                        st_q  <= WS_ENT_REQ;
                     end
                  end
               end
            end
            WS_ENT_REQ: begin
               if (inv_same)      stale_q <= 1'b1;
               if (mem_req_ready) st_q    <= WS_ENT_WAIT;
            end
            WS_ENT_WAIT: begin
               if (inv_same) stale_q <= 1'b1;
               if (mem_rsp_valid) begin
                  if (!ent_ok) begin
                     err_q <= 1'b1;
                     st_q  <= WS_IDLE;
                  end else begin
                     ptr_q <= rsp_ptr;
                     st_q  <= WS_CTRL_REQ;
                  end
               end
            end
            WS_CTRL_REQ: begin
               if (mem_req_ready) st_q <= WS_CTRL_WAIT;
            end
            WS_CTRL_WAIT: begin
               if (mem_rsp_valid) begin
                  if (!mem_rsp_data[CTRL_EN_BIT]) begin
                     err_q <= 1'b1;
                     st_q  <= WS_IDLE;
                  end else begin
                     vec_q <= mem_rsp_data[CTRL_VEC_LSB +: VEC_W];
                     cpu_q <= mem_rsp_data[CTRL_CPU_LSB +: CPU_W];
                     st_q  <= WS_PEND_REQ;
                  end
               end
            end
            WS_PEND_REQ: begin
               if (mem_req_ready) st_q <= WS_PEND_WAIT;
            end
            WS_PEND_WAIT: begin
               if (mem_rsp_valid) begin
                  word_q <= mem_rsp_data | (DW'(1) << vec_q[WB-1:0]);
                  st_q   <= WS_PEND_WR;
               end
            end
            WS_PEND_WR: begin
               if (mem_req_ready) st_q <= WS_DLV;
            end
            WS_DLV: begin
               if (dlv_ready) st_q <= WS_IDLE;
            end
            default: st_q <= WS_IDLE;
         endcase
      end
   end

   always_comb begin
      case (st_q)
         WS_ENT_REQ:  mem_req_addr = tbl_base + (PA_W'(idx_q) << ENTRY_SHIFT);
         WS_CTRL_REQ: mem_req_addr = desc_addr + PA_W'(CTRL_OFS);
         WS_PEND_REQ,
         WS_PEND_WR:  mem_req_addr = desc_addr + (PA_W'(vec_q >> WB) << BYTE_SH);
         default:     mem_req_addr = '0;
      endcase
   end

   assign mem_req_valid = (st_q == WS_ENT_REQ)  || (st_q == WS_CTRL_REQ) ||
                          (st_q == WS_PEND_REQ) || (st_q == WS_PEND_WR);
   assign mem_req_write = (st_q == WS_PEND_WR);
   assign mem_req_wdata = word_q;

   assign fill_en  = (st_q == WS_ENT_WAIT) && mem_rsp_valid && ent_ok &&
                     !stale_q && !inv_same;
   assign fill_tag = idx_q;
   assign fill_ptr = rsp_ptr;

   assign req_ready = (st_q == WS_IDLE);
   assign dlv_valid = (st_q == WS_DLV);
   assign dlv_cpu   = cpu_q;
   assign dlv_vec   = vec_q;
   assign err_flag  = err_q;

endmodule

// File: rtl/msir_translator.sv
module msir_translator
   import msir_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int MSI_DW      = 32,
   parameter int PA_W        = 48,
   parameter int DW          = 64,
   parameter int CACHE_DEPTH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              msi_valid,
   output logic              msi_ready,
   input  logic [ADDR_W-1:0] msi_addr,
   input  logic [MSI_DW-1:0] msi_data,
   input  logic              tbl_base_we,
   input  logic [PA_W-1:0]   tbl_base_wdata,
   input  logic              inv_valid,
   input  logic [15:0]       inv_index,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic              mem_req_write,
   output logic [PA_W-1:0]   mem_req_addr,
   output logic [DW-1:0]     mem_req_wdata,
   input  logic              mem_rsp_valid,
   input  logic [DW-1:0]     mem_rsp_data,
   output logic              dlv_valid,
   input  logic              dlv_ready,
   output logic [31:0]       dlv_cpu,
   output logic [7:0]        dlv_vec,
   output logic              err_flag
);

   localparam int PTR_W = PA_W - DESC_SHIFT;

   if (IDX_W != 16 || VEC_W != 8 || CPU_W != 32) begin : g_bad_layout
      $error("msir_translator: port widths do not match the structure layout");
   end

   logic [PA_W-1:0]  base_q;
   logic             dec_redir;
   logic [IDX_W-1:0] dec_index;
   logic             cache_hit;
   logic [PTR_W-1:0] cache_ptr;
   logic             fill_en;
   logic [IDX_W-1:0] fill_tag;
   logic [PTR_W-1:0] fill_ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           base_q <= '0;
      else if (tbl_base_we) base_q <= tbl_base_wdata;
   end

   msir_decode #(.ADDR_W(ADDR_W)) u_decode (
      .addr  (msi_addr),
      .redir (dec_redir),
      .index (dec_index)
   );

   msir_entry_cache #(
      .DEPTH  (CACHE_DEPTH),
      .TAG_W  (IDX_W),
      .DATA_W (PTR_W)
   ) u_cache (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_tag    (dec_index),
      .lk_hit    (cache_hit),
      .lk_data   (cache_ptr),
      .fill_en   (fill_en),
      .fill_tag  (fill_tag),
      .fill_data (fill_ptr),
      .inv_en    (inv_valid),
      .inv_tag   (inv_index)
   );

   msir_walker #(.PA_W(PA_W), .DW(DW)) u_walker (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (msi_valid),
      .req_ready     (msi_ready),
      .req_redir     (dec_redir),
      .req_index     (dec_index),
      .tbl_base      (base_q),
      .lk_hit        (cache_hit),
      .lk_ptr        (cache_ptr),
      .fill_en       (fill_en),
      .fill_tag      (fill_tag),
      .fill_ptr      (fill_ptr),
      .inv_valid     (inv_valid),
      .inv_index     (inv_index),
      .mem_req_valid (mem_req_valid),
      .mem_req_ready (mem_req_ready),
      .mem_req_write (mem_req_write),
      .mem_req_addr  (mem_req_addr),
      .mem_req_wdata (mem_req_wdata),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rsp_data  (mem_rsp_data),
      .dlv_valid     (dlv_valid),
      .dlv_ready     (dlv_ready),
      .dlv_cpu       (dlv_cpu),
      .dlv_vec       (dlv_vec),
      .err_flag      (err_flag)
   );

   logic unused_msi_data;
   assign unused_msi_data = ^msi_data;

endmodule

// File: rtl/msir_translator_chk.sv
module msir_translator_chk
   import msir_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int PA_W   = 48
) (
   input logic              clk,
   input logic              rst_n,
   input logic              msi_valid,
   input logic              msi_ready,
   input logic [ADDR_W-1:0] msi_addr,
   input logic              cache_hit,
   input logic              mem_req_valid,
   input logic              mem_req_ready,
   input logic              mem_req_write,
   input logic [PA_W-1:0]   mem_req_addr,
   input logic              dlv_valid,
   input logic              dlv_ready,
   input logic [31:0]       dlv_cpu,
   input logic [7:0]        dlv_vec,
   input logic              err_flag
);

   logic take_msi;
   assign take_msi = msi_valid && msi_ready;

   AST_DLV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      dlv_valid && !dlv_ready |=> dlv_valid && $stable(dlv_cpu) && $stable(dlv_vec)); // R6

   AST_NO_MSI_DURING_DLV: assert property (@(posedge clk) disable iff (!rst_n)
      dlv_valid |-> !msi_ready); // R6

   AST_MEM_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)); // R3

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag |=> err_flag); // R11

   AST_PLAIN_MSI_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      take_msi && !msi_addr[REDIR_BIT] |=> msi_ready && !mem_req_valid && !dlv_valid && $stable(err_flag)); // R2

   AST_HIT_SKIPS_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
      take_msi && msi_addr[REDIR_BIT] && cache_hit |=> mem_req_valid && !mem_req_write && mem_req_addr[5:0] == 6'(CTRL_OFS)); // R7

   logic unused_chk;
   assign unused_chk = ^{msi_addr, mem_req_addr};

endmodule

bind msir_translator msir_translator_chk #(.ADDR_W(ADDR_W), .PA_W(PA_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .msi_valid     (msi_valid),
   .msi_ready     (msi_ready),
   .msi_addr      (msi_addr),
   .cache_hit     (cache_hit),
   .mem_req_valid (mem_req_valid),
   .mem_req_ready (mem_req_ready),
   .mem_req_write (mem_req_write),
   .mem_req_addr  (mem_req_addr),
   .dlv_valid     (dlv_valid),
   .dlv_ready     (dlv_ready),
   .dlv_cpu       (dlv_cpu),
   .dlv_vec       (dlv_vec),
   .err_flag      (err_flag)
);

// File: tb/msir_translator_test.sv
`timescale 1ns/1ps
module msir_translator_test;

   localparam logic [47:0] DBASE = 48'h0000_2000_0000;
   localparam logic [47:0] BASE0 = 48'h0000_1000_0000;
   localparam logic [47:0] BASE1 = 48'h0000_3000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        msi_valid = 1'b0;
   logic        msi_ready;
   logic [31:0] msi_addr = '0;
   logic [31:0] msi_data = '0;
   logic        tbl_base_we = 1'b0;
   logic [47:0] tbl_base_wdata = '0;
   logic        inv_valid = 1'b0;
   logic [15:0] inv_index = '0;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b1;
   logic        mem_req_write;
   logic [47:0] mem_req_addr;
   logic [63:0] mem_req_wdata;
   logic        mem_rsp_valid = 1'b0;
   logic [63:0] mem_rsp_data = '0;
   logic        dlv_valid;
   logic        dlv_ready = 1'b1;
   logic [31:0] dlv_cpu;
   logic [7:0]  dlv_vec;
   logic        err_flag;

   always #4 clk = ~clk;  // 125 MHz

   msir_translator uut (
      .clk(clk), .rst_n(rst_n),
      .msi_valid(msi_valid), .msi_ready(msi_ready), .msi_addr(msi_addr), .msi_data(msi_data),
      .tbl_base_we(tbl_base_we), .tbl_base_wdata(tbl_base_wdata),
      .inv_valid(inv_valid), .inv_index(inv_index),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
      .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .dlv_valid(dlv_valid), .dlv_ready(dlv_ready), .dlv_cpu(dlv_cpu), .dlv_vec(dlv_vec),
      .err_flag(err_flag)
   );

   int n_chk = 0;
   int n_err = 0;
   int tbl_reads = 0;
   int all_reqs = 0;
   logic [47:0] tb_base = '0;
   logic [63:0] mem [logic [47:0]];
   logic [39:0] exp_q [$];
   logic [39:0] exp_item;

   task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", what, act, exp);
      end
   endtask

   // memory model: one-cycle read latency, writes take effect at once
   always @(posedge clk) begin
      mem_rsp_valid <= 1'b0;
      if (rst_n && mem_req_valid && mem_req_ready) begin
         all_reqs++;
         if (mem_req_write) begin
            mem[mem_req_addr] = mem_req_wdata;
         end else begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= mem.exists(mem_req_addr) ? mem[mem_req_addr] : 64'h0;
            if (mem_req_addr >= tb_base && mem_req_addr < tb_base + 48'h10_0000)
               tbl_reads++;
         end
      end
   end

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && dlv_valid && dlv_ready) begin
         if (exp_q.size() == 0) begin
            check("R4 unexpected delivery", {24'h0, dlv_cpu, dlv_vec}, 64'h0);
         end else begin
            exp_item = exp_q.pop_front();
            check("R4 delivered cpu/vector", {24'h0, dlv_cpu, dlv_vec}, {24'h0, exp_item});
         end
      end
   end

   task automatic step();
      @(posedge clk);
      #2;
   endtask

   function automatic logic [47:0] daddr(input int i);
      return DBASE + 48'(i) * 48'd64;
   endfunction

   function automatic logic [47:0] paddr(input int i, input logic [7:0] v);
      return daddr(i) + 48'(v >> 6) * 48'd8;
   endfunction

   task automatic do_reset();
      rst_n = 1'b0;
      msi_valid = 1'b0;
      inv_valid = 1'b0;
      tbl_base_we = 1'b0;
      dlv_ready = 1'b1;
      tb_base = '0;
      repeat (3) step();
      rst_n = 1'b1;
      step();
   endtask

   task automatic set_base(input logic [47:0] b);
      tbl_base_we = 1'b1;
      tbl_base_wdata = b;
      step();
      tbl_base_we = 1'b0;
      tb_base = b;
   endtask

   task automatic set_desc(input int i, input logic en, input logic [7:0] v, input logic [31:0] cpu);
      for (int k = 0; k < 4; k++) mem[daddr(i) + 48'(k * 8)] = 64'h0;
      mem[daddr(i) + 48'd32] = {cpu, 16'h0, v, 7'h0, en};
   endtask

   task automatic set_entry(input logic [15:0] idx, input logic vld, input int i);
      logic [47:0] d;
      d = daddr(i);
      mem[tb_base + (48'(idx) << 4)] = {8'hff, 8'h00, d[47:6], 5'h0, vld};
   endtask

   task automatic send_msi(input logic [15:0] idx, input logic redir, input logic [31:0] data);
      for (int g = 0; g < 1000 && !msi_ready; g++) step();
      msi_valid = 1'b1;
      msi_addr  = 32'h2FF0_0000 | (32'(idx) << 4) | (redir ? 32'h4 : 32'h0);
      msi_data  = data;
      step();
      msi_valid = 1'b0;
   endtask

   task automatic wait_idle();
      for (int g = 0; g < 1000 && !msi_ready; g++) step();
      repeat (2) step();
   endtask

   task automatic msi_expect(input logic [15:0] idx, input logic [31:0] data,
                             input logic [31:0] cpu, input logic [7:0] v);
      exp_q.push_back({cpu, v});
      send_msi(idx, 1'b1, data);
      wait_idle();
   endtask

   initial begin
      int r0;
      int q0;
      do_reset();

      // R12 reset state: {msi_ready, mem_req_valid, dlv_valid, err_flag}
      check("R12 reset outputs", {60'h0, msi_ready, mem_req_valid, dlv_valid, err_flag}, 64'h8);

      set_base(BASE0);
      set_desc(1, 1'b1, 8'h41, 32'd3);
      set_desc(2, 1'b1, 8'h07, 32'd9);
      set_entry(16'd5, 1'b1, 1);

      // R1/R3/R4/R5: first MSI misses, reads the table once, sets pending bit 65
      msi_expect(16'd5, 32'h0, 32'd3, 8'h41);
      check("R3 one table read on miss", 64'(tbl_reads), 64'd1);
      check("R5 pending bit set", mem[paddr(1, 8'h41)], 64'h2);
      check("R6 delivery drained", 64'(exp_q.size()), 64'd0);

      // R1/R7: nonzero data, cache hit, no table read
      msi_expect(16'd5, 32'hDEAD_BEEF, 32'd3, 8'h41);
      check("R7 hit makes no table read", 64'(tbl_reads), 64'd1);
      check("R5 other pending bits unchanged", mem[paddr(1, 8'h41)], 64'h2);

      // R7: memory rewritten without invalidate, cached copy still used
      set_entry(16'd5, 1'b1, 2);
      msi_expect(16'd5, 32'h0, 32'd3, 8'h41);
      check("R7 stale memory ignored while cached", 64'(tbl_reads), 64'd1);

      // R8: invalidate, next MSI refetches and sees the new entry
      inv_valid = 1'b1; inv_index = 16'd5;
      step();
      inv_valid = 1'b0;
      msi_expect(16'd5, 32'h0, 32'd9, 8'h07);
      check("R8 refetch after invalidate", 64'(tbl_reads), 64'd2);
      check("R5 pending bit 7 in word 0", mem[paddr(2, 8'h07)], 64'h80);

      // R1: highest index at the top of the table
      set_desc(6, 1'b1, 8'h00, 32'h0000_0100);
      set_entry(16'hFFFF, 1'b1, 6);
      msi_expect(16'hFFFF, 32'h0, 32'h0000_0100, 8'h00);
      check("R1 index 0xFFFF resolved", 64'(tbl_reads), 64'd3);

      // R2: non-redirected MSI is dropped
      q0 = all_reqs;
      send_msi(16'd5, 1'b0, 32'h0);
      wait_idle();
      check("R2 no memory request", 64'(all_reqs), 64'(q0));
      check("R2 no delivery and no error", {62'h0, dlv_valid, err_flag}, 64'h0);
      check("R2 no pending delivery", 64'(exp_q.size()), 64'd0);

      // R9 with R3 base register: reset, new base, round-robin replacement
      do_reset();
      set_base(BASE1);
      set_desc(3, 1'b1, 8'h90, 32'd4);
      for (int k = 20; k <= 28; k++) set_entry(16'(k), 1'b1, 3);
      r0 = tbl_reads;
      for (int k = 20; k <= 27; k++) msi_expect(16'(k), 32'h0, 32'd4, 8'h90);
      check("R3 reads at new table base", 64'(tbl_reads - r0), 64'd8);
      msi_expect(16'd28, 32'h0, 32'd4, 8'h90);
      msi_expect(16'd21, 32'h0, 32'd4, 8'h90);
      check("R9 second-oldest still cached", 64'(tbl_reads - r0), 64'd9);
      msi_expect(16'd20, 32'h0, 32'd4, 8'h90);
      check("R9 oldest was evicted", 64'(tbl_reads - r0), 64'd10);
      check("R5 pending bit 144 in word 2", mem[paddr(3, 8'h90)], 64'h1_0000);

      // R10: invalidate during the table fetch keeps it out of the cache
      set_desc(4, 1'b1, 8'hFF, 32'd7);
      set_entry(16'd30, 1'b1, 4);
      r0 = tbl_reads;
      exp_q.push_back({32'd7, 8'hFF});
      send_msi(16'd30, 1'b1, 32'h0);
      inv_valid = 1'b1; inv_index = 16'd30;
      step();
      inv_valid = 1'b0;
      wait_idle();
      check("R10 racing fetch still delivered", 64'(exp_q.size()), 64'd0);
      msi_expect(16'd30, 32'h0, 32'd7, 8'hFF);
      check("R10 stale fetch not cached", 64'(tbl_reads - r0), 64'd2);
      check("R5 pending bit 255 in word 3", mem[paddr(4, 8'hFF)], 64'h8000_0000_0000_0000);

      // R6: delivery back-pressure (index 30 now cached)
      dlv_ready = 1'b0;
      exp_q.push_back({32'd7, 8'hFF});
      send_msi(16'd30, 1'b1, 32'h0);
      repeat (12) step();
      check("R6 delivery held under back-pressure", {31'h0, dlv_valid, dlv_cpu}, {31'h0, 1'b1, 32'd7});
      check("R6 no MSI accepted while delivering", {63'h0, msi_ready}, 64'h0);
      dlv_ready = 1'b1;
      wait_idle();
      check("R6 delivery completed", 64'(exp_q.size()), 64'd0);
      check("R7 cached index reused", 64'(tbl_reads - r0), 64'd2);

      // R11: entry valid flag 0
      set_entry(16'd40, 1'b0, 5);
      send_msi(16'd40, 1'b1, 32'h0);
      wait_idle();
      check("R11 invalid entry sets error", {63'h0, err_flag}, 64'h1);
      repeat (5) step();
      check("R11 error stays set", {63'h0, err_flag}, 64'h1);
      check("R11 invalid entry not delivered", 64'(exp_q.size()), 64'd0);

      // R11: descriptor enable flag 0
      do_reset();
      check("R12 error cleared by reset", {63'h0, err_flag}, 64'h0);
      set_base(BASE0);
      set_desc(5, 1'b0, 8'h22, 32'd11);
      set_entry(16'd41, 1'b1, 5);
      send_msi(16'd41, 1'b1, 32'h0);
      wait_idle();
      check("R11 disabled descriptor sets error", {63'h0, err_flag}, 64'h1);
      check("R11 disabled descriptor not marked pending", mem[paddr(5, 8'h22)], 64'h0);
      check("R11 disabled descriptor not delivered", 64'(exp_q.size()), 64'd0);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL R6 watchdog: actual still running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule